// File: doc/BRIEF.md
# Serial Synthesizer Word Programming Controller

This block sits on the host side of a frequency synthesizer and loads its dividers over a three-wire link: a serial clock, a serial data line and a load strobe. One start request captures a reference divider value, the programmable N and A counter values and four operation bits. The block then sends two 19-bit words, most significant bit first. The last bit of each word is a destination-select bit, and each word is committed by its own load-strobe pulse.

Every interval on the link comes from a nanosecond minimum given as a parameter. The block turns each one into system clock cycles at the configured clock frequency, rounding up. Data changes only while the serial clock is low, and the serial clock idles low. A single-cycle done pulse marks the end of the transfer. The caller chooses which word goes first.

Top module: `synth_prog_ctrl`

## Requirements
- R1: After reset, `ser_clk_o`, `ser_data_o`, `ser_le_o`, `busy_o` and `done_o` are all 0.
- R2: Each word is sent as 19 rising edges of `ser_clk_o`, one bit per edge, MSB first. `ser_data_o` changes only while `ser_clk_o` is low.
- R3: The reference word, MSB to LSB, is {`cp_sel_i`, `ld_sel_i`, `pd_pol_i`, `sw_i`, `ref_div_i[13:0]`, 1}.
- R4: The programmable word, MSB to LSB, is {`n_cnt_i[10:0]`, `a_cnt_i[6:0]`, 0}.
- R5: With `order_i`=0 the reference word goes first; with `order_i`=1 the programmable word goes first. The value is captured when the start is accepted.
- R6: `ser_le_o` stays low while bits are being shifted. It pulses high once after each word, while `ser_clk_o` is low.
- R7: Each serial clock low phase lasts at least LOW_CYC cycles. Each high phase lasts exactly HIGH_CYC cycles. The load strobe is high for LEW_CYC cycles. GAP_CYC low cycles separate the first strobe from the second word.
- R8: A start request while `busy_o` is 1 is ignored. Input changes after acceptance do not alter the words in flight.
- R9: `done_o` is high for exactly one cycle, in the cycle after the second load strobe falls; `busy_o` is 0 in that cycle. `busy_o` is 1 from the cycle after acceptance until then.
- R10: Every interval is computed as ceil(ns × CLK_MHZ / 1000). The last serial clock rise precedes the load strobe rise by HIGH_CYC + TAIL_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a two-word transfer |
| order_i | input | 1 | 0: reference word first, 1: programmable word first |
| cp_sel_i | input | 1 | Charge pump current select bit |
| ld_sel_i | input | 1 | Lock-detect / divider output select bit |
| pd_pol_i | input | 1 | Phase comparator polarity bit |
| sw_i | input | 1 | Switch bit |
| ref_div_i | input | 14 | Reference divider value |
| n_cnt_i | input | 11 | Programmable N counter value |
| a_cnt_i | input | 7 | Programmable A counter value |
| ser_clk_o | output | 1 | Serial clock to the synthesizer |
| ser_data_o | output | 1 | Serial data to the synthesizer |
| ser_le_o | output | 1 | Load strobe to the synthesizer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The first transfer uses the power-on operation bits and mixed divider values, in reference-first order. It shows whether the bit order and field placement are right and whether the reference word gets destination bit 1. A second transfer sends all-ones fields in programmable-first order, and a third sends alternating patterns. Between them they catch fields that are swapped or shifted by one, and an order select that is ignored or inverted. In the last transfer a second start and changed inputs arrive mid-transfer. Any output that departs from the first request's waveform exposes a restart or a path that was not captured.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  localparam int FRAME_W = 19;
  localparam int REF_W   = 14;
  localparam int N_W     = 11;
  localparam int A_W     = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL, ST_LEH, ST_GAP, ST_DONE
  } seq_state_t;

  // Round a nanosecond minimum up to whole system clock cycles.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Operation bits, reference divider, destination bit 1.
  function automatic logic [FRAME_W-1:0] build_ref_word(
    input logic cp, input logic ld, input logic pd, input logic sw,
    input logic [REF_W-1:0] rdiv);
    return {cp, ld, pd, sw, rdiv, 1'b1};
  endfunction

  // N counter, A counter, destination bit 0.
  function automatic logic [FRAME_W-1:0] build_prog_word(
    input logic [N_W-1:0] n, input logic [A_W-1:0] a);
    return {n, a, 1'b0};
  endfunction

endpackage

// File: rtl/synth_word_pack.sv
module synth_word_pack
  import synth_prog_pkg::*;
(
  input  logic               order_i,
  input  logic               cp_sel_i,
  input  logic               ld_sel_i,
  input  logic               pd_pol_i,
  input  logic               sw_i,
  input  logic [REF_W-1:0]   ref_div_i,
  input  logic [N_W-1:0]     n_cnt_i,
  input  logic [A_W-1:0]     a_cnt_i,
  output logic [FRAME_W-1:0] word0_o,
  output logic [FRAME_W-1:0] word1_o
);

  logic [FRAME_W-1:0] ref_word;
  logic [FRAME_W-1:0] prog_word;

  always_comb begin
    ref_word  = build_ref_word(cp_sel_i, ld_sel_i, pd_pol_i, sw_i, ref_div_i);
    prog_word = build_prog_word(n_cnt_i, a_cnt_i);
    word0_o   = order_i ? prog_word : ref_word;
    word1_o   = order_i ? ref_word  : prog_word;
  end

  always_comb begin
    AST_DEST_BITS_DIFFER: assert (word0_o[0] != word1_o[0]); // R5
  end

endmodule

// File: rtl/synth_serial_engine.sv
module synth_serial_engine
  import synth_prog_pkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 3,
  parameter int TAIL_CYC = 10,
  parameter int LEW_CYC  = 2,
  parameter int GAP_CYC  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] word0_i,
  input  logic [FRAME_W-1:0] word1_i,
  output logic               sclk_o,
  output logic               sdat_o,
  output logic               sle_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int MAX_CYC = max2(max2(max2(LOW_CYC, HIGH_CYC), max2(TAIL_CYC, LEW_CYC)), GAP_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int SH_W    = 2 * FRAME_W;
  localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LD = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] LEW_LD  = CNT_W'(LEW_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);

  seq_state_t         state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic               second;
  logic [SH_W-1:0]    shreg;
  logic               sclk_q, sdat_q, sle_q, done_q;

  // Named events for the checks below.
  logic cnt_zero, last_bit, accept_ev, commit_ev;
  assign cnt_zero  = (cnt == '0);
  assign last_bit  = (bit_idx == BIT_W'(FRAME_W - 1));
  assign accept_ev = (state == ST_IDLE) && start_i;
  assign commit_ev = (state == ST_TAIL) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      second  <= 1'b0;
      shreg   <= '0;
      sclk_q  <= 1'b0;
      sdat_q  <= 1'b0;
      sle_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept_ev) begin
          shreg   <= {word0_i, word1_i};
          sdat_q  <= word0_i[FRAME_W-1];
          cnt     <= LOW_LD;
          bit_idx <= '0;
          second  <= 1'b0;
          state   <= ST_LOW;
        end
        ST_LOW: if (cnt_zero) begin
          sclk_q <= 1'b1;
          cnt    <= HIGH_LD;
          state  <= ST_HIGH;
        end else cnt <= cnt - 1'b1;
        ST_HIGH: if (cnt_zero) begin
          sclk_q <= 1'b0;
          if (last_bit) begin
            cnt   <= TAIL_LD;
            state <= ST_TAIL;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= shreg << 1;
            sdat_q  <= shreg[SH_W-2];
            cnt     <= LOW_LD;
            state   <= ST_LOW;
          end
        end else cnt <= cnt - 1'b1;
        ST_TAIL: if (commit_ev) begin
          sle_q <= 1'b1;
          cnt   <= LEW_LD;
          state <= ST_LEH;
        end else cnt <= cnt - 1'b1;
        ST_LEH: if (cnt_zero) begin
          sle_q <= 1'b0;
          if (second) begin
            done_q <= 1'b1;
            sdat_q <= 1'b0;
            state  <= ST_DONE;
          end else begin
            cnt   <= GAP_LD;
            state <= ST_GAP;
          end
        end else cnt <= cnt - 1'b1;
        ST_GAP: if (cnt_zero) begin
          second  <= 1'b1;
          bit_idx <= '0;
          shreg   <= shreg << 1;
          sdat_q  <= shreg[SH_W-2];
          cnt     <= LOW_LD;
          state   <= ST_LOW;
        end else cnt <= cnt - 1'b1;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign sdat_o = sdat_q;
  assign sle_o  = sle_q;
  assign done_o = done_q;
  assign busy_o = (state != ST_IDLE) && (state != ST_DONE);

  // Observation counters for the checks.
  logic             sclk_d;
  logic [BIT_W:0]   rise_cnt;
  logic [CNT_W:0]   hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
      hi_run   <= '0;
    end else begin
      sclk_d   <= sclk_q;
      if (sle_q) rise_cnt <= '0;
      else if (sclk_q && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      hi_run   <= sclk_q ? hi_run + 1'b1 : '0;
    end
  end

  AST_LE_QUIET_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOW || state == ST_HIGH) |-> !sle_q); // R6
  AST_LE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sle_q |-> !sclk_q); // R6
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && sclk_d) |-> $stable(sdat_q)); // R2
  AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (sle_q && !$past(sle_q)) |-> (rise_cnt == (BIT_W+1)'(FRAME_W))); // R2
  AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_q && sclk_d) |-> (hi_run == (CNT_W+1)'(HIGH_CYC))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_AFTER_LE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(sle_q) && !busy_o)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state != ST_GAP && state != ST_LEH) |=> $stable(second)); // R8

endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int T_SU_NS   = 20,
  parameter int T_HD_NS   = 20,
  parameter int T_CH_NS   = 30,
  parameter int T_CL_NS   = 30,
  parameter int T_CLE_NS  = 100,
  parameter int T_LEW_NS  = 20,
  parameter int T_GAP_NS  = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        order_i,
  input  logic        cp_sel_i,
  input  logic        ld_sel_i,
  input  logic        pd_pol_i,
  input  logic        sw_i,
  input  logic [13:0] ref_div_i,
  input  logic [10:0] n_cnt_i,
  input  logic [6:0]  a_cnt_i,
  output logic        ser_clk_o,
  output logic        ser_data_o,
  output logic        ser_le_o,
  output logic        busy_o,
  output logic        done_o
);

  // Low phase covers setup and low width; high phase covers hold and high width.
  localparam int LOW_CYC  = max2(1, max2(ns_to_cyc(T_CL_NS, CLK_MHZ), ns_to_cyc(T_SU_NS, CLK_MHZ)));
  localparam int HIGH_CYC = max2(1, max2(ns_to_cyc(T_CH_NS, CLK_MHZ), ns_to_cyc(T_HD_NS, CLK_MHZ)));
  localparam int TAIL_CYC = max2(1, ns_to_cyc(T_CLE_NS, CLK_MHZ));
  localparam int LEW_CYC  = max2(1, ns_to_cyc(T_LEW_NS, CLK_MHZ));
  localparam int GAP_CYC  = max2(1, ns_to_cyc(T_GAP_NS, CLK_MHZ));

  logic [FRAME_W-1:0] word0, word1;

  synth_word_pack u_pack (
    .order_i   (order_i),
    .cp_sel_i  (cp_sel_i),
    .ld_sel_i  (ld_sel_i),
    .pd_pol_i  (pd_pol_i),
    .sw_i      (sw_i),
    .ref_div_i (ref_div_i),
    .n_cnt_i   (n_cnt_i),
    .a_cnt_i   (a_cnt_i),
    .word0_o   (word0),
    .word1_o   (word1)
  );

  synth_serial_engine #(
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC),
    .TAIL_CYC (TAIL_CYC),
    .LEW_CYC  (LEW_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .word0_i (word0),
    .word1_i (word1),
    .sclk_o  (ser_clk_o),
    .sdat_o  (ser_data_o),
    .sle_o   (ser_le_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ser_clk_o && !ser_le_o)); // R1

endmodule

// File: tb/sim_synth_prog_ctrl.sv
module sim_synth_prog_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, order_i = 1'b0;
  logic cp_sel_i = 1'b0, ld_sel_i = 1'b0, pd_pol_i = 1'b1, sw_i = 1'b0;
  logic [13:0] ref_div_i = '0;
  logic [10:0] n_cnt_i = '0;
  logic [6:0]  a_cnt_i = '0;
  logic ser_clk_o, ser_data_o, ser_le_o, busy_o, done_o;

  always #5 clk = ~clk;

  synth_prog_ctrl u0 (.*);

  // Bench's own cycle counts: ceil(ns * 100 MHz / 1000), larger of each pair.
  function automatic int cyc(input int ns);
    int c = 0;
    while (c * 1000 < ns * 100) c++;
    return c;
  endfunction
  int lo_c, hi_c, tail_c, lew_c, gap_c;

  int checks = 0, failures = 0;
  bit finished = 0;

  // Entry: {is_ref, clk, data, le, done, busy}
  logic [5:0] exp_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_word(input logic [18:0] w, input bit is_ref, input bit last);
    for (int b = 18; b >= 0; b--) begin
      for (int k = 0; k < lo_c; k++) exp_q.push_back({is_ref, 1'b0, w[b], 3'b001});
      for (int k = 0; k < hi_c; k++) exp_q.push_back({is_ref, 1'b1, w[b], 3'b001});
    end
    for (int k = 0; k < tail_c; k++) exp_q.push_back({is_ref, 1'b0, w[0], 3'b001});
    for (int k = 0; k < lew_c; k++)  exp_q.push_back({is_ref, 1'b0, w[0], 3'b101});
    if (!last) for (int k = 0; k < gap_c; k++) exp_q.push_back({is_ref, 1'b0, w[0], 3'b001});
    else exp_q.push_back({is_ref, 1'b0, 1'b0, 3'b010});
  endtask

  task automatic run_xfer(input string tag, input logic ord, input logic [3:0] ops,
                          input logic [13:0] r, input logic [10:0] n, input logic [6:0] a,
                          input int intrude_at);
    logic [18:0] rw, pw;
    int since, lo_run, hi_run;
    logic pclk, ple;
    rw = 19'd1;
    for (int i = 0; i < 14; i++) rw[1+i] = r[i];
    rw[18:15] = ops;
    pw = 19'd0;
    for (int i = 0; i < 7; i++) pw[1+i] = a[i];
    for (int i = 0; i < 11; i++) pw[8+i] = n[i];
    exp_q.delete();
    if (!ord) begin push_word(rw, 1, 0); push_word(pw, 0, 1); end
    else      begin push_word(pw, 0, 0); push_word(rw, 1, 1); end
    for (int k = 0; k < 3; k++) exp_q.push_back(6'b000000);
    order_i = ord; {cp_sel_i, ld_sel_i, pd_pol_i, sw_i} = ops;
    ref_div_i = r; n_cnt_i = n; a_cnt_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    since = 0; lo_run = 100; hi_run = 0; pclk = 0; ple = 0;
    for (int i = 0; i < exp_q.size(); i++) begin
      logic [5:0] e = exp_q[i];
      string dreq = e[5] ? "R3" : "R4";
      if (ser_clk_o !== e[4]) chk({tag, " R2"}, "sclk", ser_clk_o, e[4]);
      else checks++;
      if (ser_data_o !== e[3]) chk({tag, " ", dreq}, $sformatf("data@%0d", i), ser_data_o, e[3]);
      else checks++;
      if (ser_le_o !== e[2]) chk({tag, " R6"}, "le", ser_le_o, e[2]);
      else checks++;
      if (done_o !== e[1]) chk({tag, " R9"}, "done", done_o, e[1]);
      else checks++;
      if (busy_o !== e[0]) chk({tag, " R9"}, "busy", busy_o, e[0]);
      else checks++;
      // Phase-width and strobe-delay measurements.
      if (ser_clk_o && !pclk) begin
        chk("R7", "low run before rise", (lo_run >= lo_c) ? 1 : 0, 1);
        since = 0;
      end else since++;
      if (!ser_clk_o && pclk) chk("R7", "high run", hi_run, hi_c);
      if (ser_le_o && !ple) chk("R10", "rise-to-strobe cycles", since, hi_c + tail_c);
      hi_run = ser_clk_o ? hi_run + 1 : 0;
      lo_run = ser_clk_o ? 0 : lo_run + 1;
      pclk = ser_clk_o; ple = ser_le_o;
      if (i == intrude_at) begin
        start_i = 1'b1; order_i = ~ord; ref_div_i = ~r; n_cnt_i = ~n; a_cnt_i = ~a;
        cp_sel_i = ~ops[3];
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    lo_c   = (cyc(30) > cyc(20)) ? cyc(30) : cyc(20);
    hi_c   = (cyc(30) > cyc(20)) ? cyc(30) : cyc(20);
    tail_c = cyc(100);
    lew_c  = cyc(20);
    gap_c  = cyc(100);
    repeat (3) @(negedge clk);
    chk("R1", "sclk reset", ser_clk_o, 0);
    chk("R1", "data reset", ser_data_o, 0);
    chk("R1", "le reset", ser_le_o, 0);
    chk("R1", "busy reset", busy_o, 0);
    chk("R1", "done reset", done_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after release", {ser_clk_o, ser_le_o, busy_o}, 0);
    // Power-on operation bits, reference first.
    run_xfer("R3", 1'b0, 4'b0010, 14'h2A5B, 11'h5A3, 7'h35, -1);
    // Programmable first, all-ones fields.
    run_xfer("R5", 1'b1, 4'b1111, 14'h3FFF, 11'h7FF, 7'h7F, -1);
    // Alternating patterns, programmable first.
    run_xfer("R4", 1'b1, 4'b0101, 14'h1555, 11'h2AA, 7'h55, -1);
    // Restart attempt with changed inputs mid-transfer.
    run_xfer("R8", 1'b0, 4'b1010, 14'h0F0F, 11'h0F1, 7'h0E, 60);
    chk("R9", "idle at end", busy_o, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule